// File: doc/BRIEF.md
# Multi-Line Edge Interrupt and Wake Event Controller

This block watches a set of asynchronous request lines (by default nineteen: sixteen taken from pins chosen by an external pin multiplexer, plus three fed by internal sources such as a supply monitor, a real-time alarm and a bus wake-up detector) and turns selected edges on them into requests. Each line can be armed for rising edges, falling edges or both, and software can also raise a request on any line.

A detected request goes two ways. It can latch a per-line pending flag, which drives a level interrupt output toward the interrupt controller while the line is unmasked. It can also produce a single-cycle wake pulse, which system power control uses to leave a low-power state. Each path has its own per-line mask. Software clears pending flags by writing ones to them. Six registers sit behind a small synchronous register port.

Top module: `extint_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0, and `irq_out` and `evt_out` are all 0.
- R2: Each line passes through two synchronizer flops and then an edge detector. A level change on `line_in` applied before clock edge E1 latches the pending bit after edge E3, and `irq_out` follows after the same edge when the line is unmasked. The edge is a rising one when rise-enable (address 2) is set and a falling one when fall-enable (address 3) is set.
- R3: When both enables are set, either edge is detected. When neither is set, no edge on that line has any effect.
- R4: A detected request sets a line's pending bit only if the line's interrupt mask bit (address 0, 1 = enabled) is 1 in the cycle of detection.
- R5: While a line's event mask bit (address 1, 1 = enabled) is set, each detected request produces a pulse on that line's `evt_out` bit that is exactly one clock wide. This happens regardless of the interrupt mask.
- R6: A write to the software trigger register (address 4) raises a request on each line whose bit goes from 0 to 1. The request takes effect at the clock edge that performs the write. Writing 1 to a bit that already holds 1 raises nothing.
- R7: Writing to the pending register (address 5) clears each pending bit written as 1, and the software trigger bit of the same line. Bits written as 0 are left unchanged.
- R8: If a new request is detected in the same cycle that its pending bit is cleared, the pending bit stays set.
- R9: Each `irq_out` bit equals the line's pending bit ANDed with its interrupt mask bit. Masking a pending line drops its output but keeps the pending bit.
- R10: `reg_rdata` returns the register selected by `reg_addr` one clock later. Addresses 6 and 7 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | Asynchronous request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 imask, 1 emask, 2 rise, 3 fall, 4 swtrig, 5 pending) |
| reg_wdata | input | NUM_LINES | Write data, one bit per line |
| reg_rdata | output | NUM_LINES | Registered read data |
| irq_out | output | NUM_LINES | Per-line interrupt requests, registered |
| evt_out | output | NUM_LINES | Per-line one-cycle wake pulses, registered |

## Verification
The hardest case to reach is a pending clear that lands in the very cycle an edge is detected. The detection cycle sits two synchronizer stages behind the pin, so the bench sets the pending bit through the software trigger first. It then raises the pin and issues the clearing write exactly two clocks later, so that the write meets the detection. Afterwards the pending bit must still be set and the software trigger bit must be clear. A second awkward case is a software trigger rewritten while its bit is already 1. The bench creates that state by triggering with the interrupt mask off, so nothing latches, and then repeats the write with the mask on.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_IMASK  = 3'd0,
    A_EMASK  = 3'd1,
    A_RISE   = 3'd2,
    A_FALL   = 3'd3,
    A_SWTRIG = 3'd4,
    A_PEND   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/extint_edge.sv
module extint_edge #(
  parameter int N      = 19,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[DEPTH-2:0], async_in[i]};
    end
    // sh[DEPTH-2] is the synchronized level, sh[DEPTH-1] its previous value
    assign rise[i] =  sh[DEPTH-2] & ~sh[DEPTH-1];
    assign fall[i] = ~sh[DEPTH-2] &  sh[DEPTH-1];
  end
endmodule

// File: rtl/extint_line.sv
module extint_line (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fall,
  input  logic rise_en,
  input  logic fall_en,
  input  logic sw_set,
  input  logic imask,
  input  logic imask_nxt,
  input  logic emask,
  input  logic clr,
  output logic trig,
  output logic pend,
  output logic irq,
  output logic evt
);
  logic pend_nxt;

  assign trig     = (rise & rise_en) | (fall & fall_en) | sw_set;
  assign pend_nxt = (pend & ~clr) | (trig & imask);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
      evt  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= pend_nxt & imask_nxt;
      evt  <= trig & emask;
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_LINES = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic [NUM_LINES-1:0] irq_out,
  output logic [NUM_LINES-1:0] evt_out
);
  localparam int N = NUM_LINES;

  logic [N-1:0] imask_q, emask_q, rise_q, fall_q, sw_q;
  logic [N-1:0] imask_nxt, sw_set_v, clr_v;
  logic [N-1:0] rise_v, fall_v, trig_v, pend_v;
  logic         wr_imask, wr_sw, wr_pend;

  assign wr_imask  = reg_we && (reg_addr == A_IMASK);
  assign wr_sw     = reg_we && (reg_addr == A_SWTRIG);
  assign wr_pend   = reg_we && (reg_addr == A_PEND);
  assign imask_nxt = wr_imask ? reg_wdata : imask_q;
  assign sw_set_v  = wr_sw ? (reg_wdata & ~sw_q) : '0;
  assign clr_v     = wr_pend ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      sw_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_IMASK:  imask_q <= reg_wdata;
        A_EMASK:  emask_q <= reg_wdata;
        A_RISE:   rise_q  <= reg_wdata;
        A_FALL:   fall_q  <= reg_wdata;
        A_SWTRIG: sw_q    <= reg_wdata;
        A_PEND:   sw_q    <= sw_q & ~reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_IMASK:  reg_rdata <= imask_q;
        A_EMASK:  reg_rdata <= emask_q;
        A_RISE:   reg_rdata <= rise_q;
        A_FALL:   reg_rdata <= fall_q;
        A_SWTRIG: reg_rdata <= sw_q;
        A_PEND:   reg_rdata <= pend_v;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  extint_edge #(.N(N), .STAGES(2)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (line_in),
    .rise     (rise_v),
    .fall     (fall_v)
  );

  for (genvar i = 0; i < N; i++) begin : g_ln
    extint_line u_line (
      .clk       (clk),
      .rst       (rst),
      .rise      (rise_v[i]),
      .fall      (fall_v[i]),
      .rise_en   (rise_q[i]),
      .fall_en   (fall_q[i]),
      .sw_set    (sw_set_v[i]),
      .imask     (imask_q[i]),
      .imask_nxt (imask_nxt[i]),
      .emask     (emask_q[i]),
      .clr       (clr_v[i]),
      .trig      (trig_v[i]),
      .pend      (pend_v[i]),
      .irq       (irq_out[i]),
      .evt       (evt_out[i])
    );
  end
endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
  parameter int N = 19
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] imask,
  input logic [N-1:0] emask,
  input logic [N-1:0] pend,
  input logic [N-1:0] trig,
  input logic [N-1:0] clr,
  input logic [N-1:0] irq,
  input logic [N-1:0] evt
);
  a_r4_pend_needs_mask: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(imask)) == '0));

  a_r5_evt_masked: assert property (@(posedge clk) disable iff (rst)
    ((evt & ~$past(emask)) == '0));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    ((pend & $past(clr) & ~$past(trig)) == '0));

  a_r8_set_over_clear: assert property (@(posedge clk) disable iff (rst)
    ((~pend & $past(trig) & $past(imask)) == '0));

  a_r9_irq_subset: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~(pend & imask)) == '0));
endmodule

bind extint_ctrl extint_chk #(.N(NUM_LINES)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .imask (imask_q),
  .emask (emask_q),
  .pend  (pend_v),
  .trig  (trig_v),
  .clr   (clr_v),
  .irq   (irq_out),
  .evt   (evt_out)
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
  localparam int N = 19;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] line_in = '0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, irq_out, evt_out;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  extint_ctrl #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .line_in(line_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .evt_out(evt_out)
  );

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, b, all;
    all = '1;
    tick(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq_out, '0);
    chk("R1 evt", evt_out, '0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg", v, '0);
    end

    // R10 register readback and unused addresses
    for (int a = 0; a < 4; a++) begin
      wr(3'(a), N'(32'h5A5A5 + a * 32'h111));
      rd(3'(a), v); chk("R10 readback", v, N'(32'h5A5A5 + a * 32'h111));
    end
    wr(3'd6, all); wr(3'd7, all);
    rd(3'd6, v); chk("R10 addr6", v, '0);
    rd(3'd7, v); chk("R10 addr7", v, '0);
    wr(3'd2, '0); wr(3'd3, '0);
    wr(3'd5, all);
    rd(3'd5, v); chk("R10 pend clean", v, '0);

    // R2 R3 R5 edge sweep: every line, every enable combination
    wr(3'd0, all); wr(3'd1, all);
    for (int l = 0; l < N; l++) begin
      b = N'(1) << l;
      for (int m = 0; m < 4; m++) begin
        logic r, f;
        r = m[0]; f = m[1];
        wr(3'd2, r ? b : '0);
        wr(3'd3, f ? b : '0);
        line_in = b;
        tick(2);
        chk("R2 latency irq", irq_out, '0);
        tick(1);
        chk("R2 R3 rise irq", irq_out, r ? b : '0);
        chk("R5 rise evt", evt_out, r ? b : '0);
        tick(1);
        chk("R5 one cycle", evt_out, '0);
        wr(3'd5, all);
        chk("R7 cleared", irq_out, '0);
        line_in = '0;
        tick(3);
        chk("R3 fall irq", irq_out, f ? b : '0);
        chk("R5 fall evt", evt_out, f ? b : '0);
        tick(1);
        chk("R5 one cycle f", evt_out, '0);
        wr(3'd5, all);
      end
    end

    // R4 masked line: event pulse but no pending
    b = N'(1) << 4;
    wr(3'd2, all); wr(3'd3, '0);
    wr(3'd0, ~b);
    line_in = b;
    tick(3);
    chk("R4 evt still pulses", evt_out, b);
    chk("R4 no irq", irq_out, '0);
    rd(3'd5, v); chk("R4 no pending", v, '0);
    line_in = '0; tick(4);

    // R9 masking a pending line
    wr(3'd0, all);
    line_in = b; tick(3);
    chk("R9 irq set", irq_out, b);
    wr(3'd0, ~b);
    chk("R9 irq masked", irq_out, '0);
    rd(3'd5, v); chk("R9 pending kept", v, b);
    wr(3'd0, all);
    chk("R9 irq back", irq_out, b);
    wr(3'd5, all);
    line_in = '0; tick(4);

    // R6 software trigger; R7 clears it with pending
    wr(3'd2, '0);
    for (int l = 0; l < N; l += 3) begin
      b = N'(1) << l;
      wr(3'd4, b);
      chk("R6 sw irq", irq_out, b);
      chk("R6 sw evt", evt_out, b);
      tick(1);
      chk("R6 sw evt one cycle", evt_out, '0);
      wr(3'd5, b);
      chk("R7 irq cleared", irq_out, '0);
      rd(3'd4, v); chk("R7 sw cleared", v, '0);
    end
    // R6 rewrite of a bit already at 1
    b = N'(1) << 7;
    wr(3'd0, '0);
    wr(3'd4, b);
    wr(3'd0, all);
    wr(3'd4, b);
    chk("R6 no retrigger irq", irq_out, '0);
    chk("R6 no retrigger evt", evt_out, '0);
    rd(3'd5, v); chk("R6 no retrigger pend", v, '0);
    wr(3'd5, all);

    // R7 zero bits leave pending alone
    wr(3'd4, (N'(1) << 2) | (N'(1) << 9));
    wr(3'd5, N'(1) << 2);
    chk("R7 partial clear", irq_out, N'(1) << 9);
    rd(3'd4, v); chk("R7 partial sw", v, N'(1) << 9);
    wr(3'd5, all);

    // R8 clear coincident with a new detected edge
    b = N'(1) << 11;
    wr(3'd2, all);
    wr(3'd4, b);
    line_in = b;
    tick(2);
    wr(3'd5, b);
    chk("R8 pending held irq", irq_out, b);
    rd(3'd5, v); chk("R8 pending held", v, b);
    rd(3'd4, v); chk("R8 sw cleared", v, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule